// File: doc/BRIEF.md
# Redundant Bit-Stream Multiplier with Voted Decoder

This block multiplies two small unsigned operands by expressing the product as a stream of bits whose number of ones equals the product. Every pair of operand bits is ANDed. The result is then copied into a run of positions as long as that pair's binary weight. The runs are grouped by weight, heaviest first, to form a base stream of `(2^OPW-1)^2` bits.

To survive several bit flips at once, each base bit is widened to `REP` identical copies. A short offset tail is added after the copies. The tail holds `REP/2` ones followed by `REP/2-1` zeros.

A decoder recovers the binary product. It counts the ones and divides by `REP` with floor rounding. Because of the offset tail, any net count error from `-REP/2` to `REP/2-1` rounds away. The decoder is built three times, and a bitwise two-of-three vote combines the copies. Each copy has its own XOR fault mask input, so a test can corrupt the stream seen by one copy or by all three. The voted product is registered on a valid strobe.

Top module: `bsm_mult_top`

## Requirements
- R1: With `OPW=3` and `REP=8`, the number of ones on `stream_o` always equals `8*op_a*op_b + 4`, and the stream is 399 bits wide.
- R2: Base stream position p (48 down to 0) is built as follows. The segments are taken by weight 16, 8, 4, 2, 1, from the top down. Within a segment, each pair `op_a[i] & op_b[j]` with `i+j` equal to that weight's log2 fills `2^(i+j)` consecutive positions. Pairs are ordered by `i` from high to low.
- R3: Base position p occupies `stream_o[7+8p+7 : 7+8p]`, and all 8 of its copies carry the same value.
- R4: The lowest 7 bits of `stream_o` are `7'b1111000`.
- R5: One clock after a cycle with `in_valid` high, `out_valid` is high and `product_o` equals the product of the operands sampled in that cycle. After a cycle with `in_valid` low, `out_valid` is low.
- R6: The same flip mask may be applied to all three decoders. If its net error (zeros flipped to one, minus ones flipped to zero) lies in -4..+3, the product is exact. A net of +4 adds one to the product, and a net of -5 subtracts one.
- R7: Any flip mask confined to a single decoder, with the other two masks zero, leaves `product_o` exact.
- R8: While `rst_n` is low, `out_valid` and `product_o` are cleared at each clock.
- R9: `product_o` holds its value while `in_valid` stays low, whatever the operands and masks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 3 | First operand, unsigned |
| op_b | input | 3 | Second operand, unsigned |
| flip_m0 | input | 399 | XOR fault mask seen by decoder 0 |
| flip_m1 | input | 399 | XOR fault mask seen by decoder 1 |
| flip_m2 | input | 399 | XOR fault mask seen by decoder 2 |
| stream_o | output | 399 | Redundant stream, not masked, combinational from the operands |
| out_valid | output | 1 | Product valid |
| product_o | output | 6 | Voted decoded product |

## Verification
`stream_o` is combinational, so it is checked within the same cycle. The check runs one time unit after the operands change on the falling edge, before the next rising edge. The product and `out_valid` are due at the first rising edge after a strobe. The driver pushes each expected product into a queue when it raises `in_valid`. The monitor wakes 2 ns after every rising edge and pops one entry for each cycle in which `out_valid` is high, so it compares results in issue order without counting cycles itself. The hold check waits two idle edges and then confirms that `out_valid` is low and the product has not moved.

// File: rtl/bsm_pkg.sv
// Package: shared sizing helpers for the redundant bit-stream multiplier.
// Assumes operands of at least 1 bit and a power-of-two repetition factor.
package bsm_pkg;

    // Length of the base stream: the largest product value.
    function automatic int base_len(input int opw);
        return ((1 << opw) - 1) * ((1 << opw) - 1);
    endfunction

    // Full redundant length: REP copies of each base bit plus a REP-1 bit tail.
    function automatic int stream_len(input int opw, input int rep);
        return base_len(opw) * rep + (rep - 1);
    endfunction

endpackage

// File: rtl/bsm_stream_gen.sv
// Module: builds the redundant unary stream for op_a * op_b.
// The base stream holds weighted bit-pair products, heaviest segment on top.
// Each base bit is widened to REP copies, and an offset tail of REP/2 ones
// then REP/2-1 zeros is added. Purely combinational.
module bsm_stream_gen #(
    parameter int OPW = 3,
    parameter int REP = 8
) (
    input  logic [OPW-1:0]                          op_a,
    input  logic [OPW-1:0]                          op_b,
    output logic [bsm_pkg::stream_len(OPW,REP)-1:0] stream
);
    localparam int BASE_W    = bsm_pkg::base_len(OPW);
    localparam int TAIL_W    = REP - 1;
    localparam int TAIL_ONES = REP / 2;

    logic [BASE_W-1:0] base;

    // Fill the base stream top-down: by weight, then by op_a bit index high to low.
    always_comb begin
        int pos;
        base = '0;
        pos  = BASE_W;
        for (int k = 2*OPW-2; k >= 0; k--) begin
            for (int i = OPW-1; i >= 0; i--) begin
                if ((k - i) >= 0 && (k - i) < OPW) begin
                    for (int r = 0; r < (1 << k); r++) begin
                        pos = pos - 1;
                        base[pos] = op_a[i] & op_b[k-i];
                    end
                end
            end
        end
    end

    // Widen every base bit to REP identical copies above the tail.
    for (genvar g = 0; g < BASE_W; g++) begin : g_rep
        assign stream[TAIL_W + g*REP +: REP] = {REP{base[g]}};
    end

    // Constant offset tail: TAIL_ONES ones followed by zeros.
    assign stream[TAIL_W-1:0] = {{TAIL_ONES{1'b1}}, {(TAIL_W-TAIL_ONES){1'b0}}};

endmodule

// File: rtl/bsm_decoder.sv
// Module: one decoder copy. Counts the ones of (stream ^ mask) and divides
// by REP with floor rounding. Assumes REP is a power of two and that the
// quotient fits PROD_W bits.
module bsm_decoder #(
    parameter int STR_W  = 399,
    parameter int REP    = 8,
    parameter int PROD_W = 6
) (
    input  logic [STR_W-1:0]  stream,
    input  logic [STR_W-1:0]  mask,
    output logic [PROD_W-1:0] value
);
    localparam int CNT_W  = $clog2(STR_W + 1);
    localparam int REP_LG = $clog2(REP);

    logic [STR_W-1:0] seen;
    logic [CNT_W-1:0] ones;

    assign seen = stream ^ mask;

    // Population count of the stream as this copy sees it.
    always_comb begin
        ones = '0;
        for (int n = 0; n < STR_W; n++) begin
            ones = ones + CNT_W'(seen[n]);
        end
    end

    // Floor division by REP is a right shift.
    assign value = ones[REP_LG +: PROD_W];

endmodule

// File: rtl/bsm_voter.sv
// Module: bitwise two-of-three majority over W-bit words.
// Assumes at most one input disagrees in any given bit position.
module bsm_voter #(
    parameter int W = 6
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] in2,
    output logic [W-1:0] voted
);
    assign voted = (in0 & in1) | (in0 & in2) | (in1 & in2);
endmodule

// File: rtl/bsm_mult_top.sv
// Module: redundant bit-stream multiplier top. Generates the stream and
// decodes it with three masked decoders. The voted product is registered
// when in_valid is high. Synchronous active-low reset.
module bsm_mult_top #(
    parameter int OPW    = 3,
    parameter int REP    = 8,
    parameter int STR_W  = bsm_pkg::stream_len(OPW, REP),
    parameter int PROD_W = $clog2(bsm_pkg::base_len(OPW) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    input  logic [STR_W-1:0]  flip_m0,
    input  logic [STR_W-1:0]  flip_m1,
    input  logic [STR_W-1:0]  flip_m2,
    output logic [STR_W-1:0]  stream_o,
    output logic              out_valid,
    output logic [PROD_W-1:0] product_o
);
    localparam int COPIES = 3;

    logic [STR_W-1:0]  masks [COPIES];
    logic [PROD_W-1:0] dec_val [COPIES];
    logic [PROD_W-1:0] voted;

    assign masks[0] = flip_m0;
    assign masks[1] = flip_m1;
    assign masks[2] = flip_m2;

    bsm_stream_gen #(.OPW(OPW), .REP(REP)) u_gen (
        .op_a   (op_a),
        .op_b   (op_b),
        .stream (stream_o)
    );

    for (genvar c = 0; c < COPIES; c++) begin : g_dec
        bsm_decoder #(.STR_W(STR_W), .REP(REP), .PROD_W(PROD_W)) u_dec (
            .stream (stream_o),
            .mask   (masks[c]),
            .value  (dec_val[c])
        );
    end

    bsm_voter #(.W(PROD_W)) u_vote (
        .in0   (dec_val[0]),
        .in1   (dec_val[1]),
        .in2   (dec_val[2]),
        .voted (voted)
    );

    // Capture the voted product on a strobe; valid follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product_o <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product_o <= voted;
        end
    end

endmodule

// File: rtl/bsm_mult_chk.sv
// Checker: temporal properties of bsm_mult_top, bound to every instance.
module bsm_mult_chk #(
    parameter int OPW    = 3,
    parameter int REP    = 8,
    parameter int STR_W  = 399,
    parameter int PROD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPW-1:0]    op_a,
    input logic [OPW-1:0]    op_b,
    input logic [STR_W-1:0]  flip_m0,
    input logic [STR_W-1:0]  flip_m1,
    input logic [STR_W-1:0]  flip_m2,
    input logic [STR_W-1:0]  stream_o,
    input logic              out_valid,
    input logic [PROD_W-1:0] product_o
);
    // R1: the stream's ones count encodes the product with the offset.
    a_r1_ones_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stream_o) == REP * (int'(op_a) * int'(op_b)) + REP / 2);

    // R5: a strobe produces a valid result on the next edge.
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5: no strobe means no valid result on the next edge.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: the product holds through idle cycles.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product_o));

    // R6: with clean masks the registered product is exact.
    a_r6_clean_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flip_m0 == '0 && flip_m1 == '0 && flip_m2 == '0)
        |=> int'(product_o) == $past(int'(op_a) * int'(op_b)));
endmodule

bind bsm_mult_top bsm_mult_chk #(
    .OPW(OPW), .REP(REP), .STR_W(STR_W), .PROD_W(PROD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .flip_m0(flip_m0), .flip_m1(flip_m1), .flip_m2(flip_m2),
    .stream_o(stream_o), .out_valid(out_valid), .product_o(product_o)
);

// File: tb/bsm_mult_top_tb.sv
// Scoreboard bench for bsm_mult_top.
module bsm_mult_top_tb;
    localparam int STR_W = 399;

    typedef struct {
        int    expv;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [2:0]       op_a = '0;
    logic [2:0]       op_b = '0;
    logic [STR_W-1:0] flip_m0 = '0;
    logic [STR_W-1:0] flip_m1 = '0;
    logic [STR_W-1:0] flip_m2 = '0;
    logic [STR_W-1:0] stream_o;
    logic             out_valid;
    logic [5:0]       product_o;

    int    n_checks = 0;
    int    n_fail = 0;
    item_t sb[$];

    bsm_mult_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .flip_m0(flip_m0), .flip_m1(flip_m1), .flip_m2(flip_m2),
        .stream_o(stream_o), .out_valid(out_valid), .product_o(product_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected stream built from R2, R3 and R4.
    function automatic logic [STR_W-1:0] exp_stream(input logic [2:0] a, input logic [2:0] b);
        logic [48:0] bs;
        logic [STR_W-1:0] s;
        int p;
        bs = '0;
        p = 49;
        for (int w = 4; w >= 0; w--)
            for (int i = 2; i >= 0; i--)
                if (w - i >= 0 && w - i <= 2)
                    for (int r = 0; r < (1 << w); r++) begin
                        p--;
                        bs[p] = a[i] & b[w-i];
                    end
        for (int q = 0; q < 49; q++)
            for (int c = 0; c < 8; c++) s[7 + 8*q + c] = bs[q];
        s[6:0] = 7'b1111000;
        return s;
    endfunction

    // Mask that flips nplus zeros and nminus ones of stream s.
    function automatic logic [STR_W-1:0] mk_mask(input logic [STR_W-1:0] s, input int nplus, input int nminus);
        logic [STR_W-1:0] m;
        int idx;
        m = '0;
        for (int k = 0; k < nplus; k++) begin
            do idx = $urandom_range(STR_W-1, 0); while (s[idx] || m[idx]);
            m[idx] = 1'b1;
        end
        for (int k = 0; k < nminus; k++) begin
            do idx = $urandom_range(STR_W-1, 0); while (!s[idx] || m[idx]);
            m[idx] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [STR_W-1:0] rnd_vec();
        logic [STR_W-1:0] v;
        for (int k = 0; k < STR_W; k++) v[k] = 1'($urandom);
        return v;
    endfunction

    // Driver: apply one strobe, check the combinational stream, queue the product.
    task automatic drive(input int a, input int b, input logic [STR_W-1:0] m0,
                         input logic [STR_W-1:0] m1, input logic [STR_W-1:0] m2,
                         input int expv, input string tag);
        logic [STR_W-1:0] es;
        item_t it;
        @(negedge clk);
        op_a = 3'(a); op_b = 3'(b);
        flip_m0 = m0; flip_m1 = m1; flip_m2 = m2;
        in_valid = 1'b1;
        it.expv = expv; it.tag = tag;
        sb.push_back(it);
        #1;
        es = exp_stream(3'(a), 3'(b));
        check(stream_o == es, "R2 R3 R4 stream layout", longint'(stream_o[63:0]), longint'(es[63:0]));
        check($countones(stream_o) == 8*a*b + 4, "R1 ones count", $countones(stream_o), 8*a*b + 4);
    endtask

    // Monitor: pop and compare each valid result 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) check(1'b0, "R5 unexpected valid", 1, 0);
                else begin
                    item_t it;
                    it = sb.pop_front();
                    check(int'(product_o) == it.expv, it.tag, product_o, it.expv);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [STR_W-1:0] s, m;
        int nplus, nminus, last;
        // R8: reset state.
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
        check(product_o == 6'd0, "R8 reset product", product_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                s = exp_stream(3'(a), 3'(b));
                // R5: clean multiply.
                drive(a, b, '0, '0, '0, a*b, "R5 clean product");
                // R6: shared mask within the tolerated net error.
                nplus = $urandom_range(3, 0);
                nminus = $urandom_range(4, 0);
                m = mk_mask(s, nplus, nminus);
                drive(a, b, m, m, m, a*b, "R6 in-range shared flips");
                // R7: heavy random mask on one decoder only.
                case ((a + b) % 3)
                    0: drive(a, b, rnd_vec(), '0, '0, a*b, "R7 single decoder fault");
                    1: drive(a, b, '0, ~'0, '0, a*b, "R7 single decoder fault");
                    default: drive(a, b, '0, '0, rnd_vec(), a*b, "R7 single decoder fault");
                endcase
                // R6: boundaries just outside the tolerated range.
                if (a*b <= 48) begin
                    m = mk_mask(s, 4, 0);
                    drive(a, b, m, m, m, a*b + 1, "R6 net +4 rounds up");
                end
                if (a*b >= 1) begin
                    m = mk_mask(s, 0, 5);
                    drive(a, b, m, m, m, a*b - 1, "R6 net -5 rounds down");
                end
            end
        end

        // Back-to-back idle, then the R9 hold check.
        drive(5, 6, '0, '0, '0, 30, "R5 last product");
        @(negedge clk);
        in_valid = 1'b0;
        op_a = 3'd7; op_b = 3'd7; flip_m0 = ~'0;
        last = 30;
        @(posedge clk); @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R5 valid drops when idle", out_valid, 0);
        check(int'(product_o) == last, "R9 product holds", product_o, last);
        check(sb.size() == 0, "R5 all results delivered", sb.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule